// File: doc/BRIEF.md
# Serial Configuration Flash Command Engine

This block is the device side of a serial configuration memory. A host selects it with an active-low select, toggles a serial clock and presents one bit per rising clock edge. Each transaction starts with an 8-bit operation code and may continue with address bytes, data bytes, or both. Read-type operations then return bytes on a serial output. Modifying operations act on a byte array only when the host ends the transaction cleanly.

The array has `4*SECTOR_BYTES` bytes and is split into four equal sectors. A write-enable latch and a busy timer gate every modifying operation. All serial inputs are sampled by the system clock `clk`, and a serial clock edge is detected one cycle after it happens. The bench keeps the array small. A full-size part would set `SECTOR_BYTES` to 32768.

Top module: `flash_cmd_engine`

## Requirements
- R1: While `cs_n` is low, each rising edge of `sclk` captures `sdi`, and bits are assembled most-significant first. While `cs_n` is high, the bit and byte counters return to zero.
- R2: The recognised codes are 0x06 (set write latch), 0x04 (clear write latch), 0x05 (status read), 0x01 (status write), 0x03 (data read), 0x02 (byte program), 0xD8 (sector erase), 0xC7 (full erase) and 0xAB (identifier read). Any other code causes no output and no change of state.
- R3: A data read is 0x03 followed by a 24-bit address sent MSB first. Data bytes follow MSB first, starting with the clock after the last address bit. The address increments after each byte and wraps from the top of the array to 0.
- R4: A status read is 0x05. It returns the status byte repeatedly until `cs_n` rises: bit 0 is busy, bit 1 is the write latch, bits 4:2 are the protect field and bits 7:5 read 0. The host may end the read after any bit.
- R5: An identifier read is 0xAB followed by three dummy bytes. It then returns `SILICON_ID` repeatedly.
- R6: `sdo_oe` is high only while the block is selected and in the data-out phase of a read. It is never high before an operation code has been received.
- R7: 0x06 sets the write latch and 0x04 clears it.
- R8: A modifying command takes effect only if `cs_n` rises after a whole multiple of eight `sclk` rises. Otherwise it has no effect at all, and the write latch also stays as it was.
- R9: A byte program is 0x02, a 24-bit address and one data byte. It replaces the stored byte with the old byte AND the data. It executes only with the write latch set and busy clear.
- R10: A sector erase is 0xD8 with a 24-bit address. It sets every byte of the sector chosen by the top two array-address bits to 0xFF. A full erase (0xC7) sets the whole array to 0xFF. Both need the write latch set and busy clear.
- R11: A status write is 0x01 followed by one byte. Bits 4:2 of that byte are stored as the protect field, under the same enable conditions as R9.
- R12: A committed program, erase or status write clears the write latch and holds busy for `BUSY_CLKS` clocks. While busy is set, those commands are rejected and the write latch is left unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock that samples all serial pins |
| rst_n | input | 1 | Asynchronous active-low reset; the array resets to 0xFF |
| cs_n | input | 1 | Active-low select |
| sclk | input | 1 | Serial clock from the host |
| sdi | input | 1 | Serial data in, MSB first |
| sdo | output | 1 | Serial data out, MSB first |
| sdo_oe | output | 1 | Drive enable for `sdo` |

## Verification
The assertions check on every cycle that the output is enabled only after an operation code and that the counters clear while deselected. They also check that the write latch rises only through a cleanly ended set-latch command, that a misaligned end changes neither the latch nor the busy flag, and that busy starts only from a clean end with the latch set. The bench scenarios cover what only data can show. These are the AND rule of programming across the whole array, the erase of a chosen sector, address wrap, identifier and status contents, and the rejection of commands that are misaligned, have no latch, or arrive while busy.

// File: rtl/flash_cmd_engine.sv
module flash_cmd_engine #(
  parameter int SECTOR_BYTES = 32,
  parameter int BUSY_CLKS    = 200,
  parameter logic [7:0] SILICON_ID = 8'h10
) (
  input  logic clk,
  input  logic rst_n,
  input  logic cs_n,
  input  logic sclk,
  input  logic sdi,
  output logic sdo,
  output logic sdo_oe
);
  localparam int DEPTH = 4 * SECTOR_BYTES;
  localparam int AW    = $clog2(DEPTH);
  localparam int BW    = $clog2(BUSY_CLKS + 1);
  localparam logic [7:0] OP_WREN = 8'h06, OP_WRDI = 8'h04, OP_RDSR = 8'h05,
                         OP_WRSR = 8'h01, OP_READ = 8'h03, OP_PROG = 8'h02,
                         OP_SE   = 8'hD8, OP_BE   = 8'hC7, OP_RDID = 8'hAB;

  logic [7:0]    mem [DEPTH];
  logic          sclk_q, cs_q, wel, outph;
  logic [2:0]    bitcnt, bytecnt, prot;
  logic [6:0]    sh;
  logic [7:0]    op, wdata, out_sh;
  logic [AW-1:0] addr;
  logic [BW-1:0] busy_cnt;
  logic          busy, rise, byte_done, commit, do_mod;
  logic [7:0]    byte_in, status;
  logic [AW-1:0] addr_nx;

  assign busy      = busy_cnt != '0;
  assign rise      = sclk & ~sclk_q & ~cs_n;
  assign byte_done = rise && bitcnt == 3'd7;
  assign byte_in   = {sh, sdi};
  assign addr_nx   = AW'({addr, byte_in});
  assign commit    = cs_n & ~cs_q & (bitcnt == 3'd0);
  assign status    = {3'b000, prot, wel, busy};
  assign sdo       = out_sh[7];
  assign sdo_oe    = outph & ~cs_n;

  always_comb begin
    do_mod = 1'b0;
    if (commit && wel && !busy)
      case (op)
        OP_PROG: do_mod = bytecnt >= 3'd5;
        OP_WRSR: do_mod = bytecnt >= 3'd2;
        OP_SE:   do_mod = bytecnt >= 3'd4;
        OP_BE:   do_mod = 1'b1;
        default: do_mod = 1'b0;
      endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sclk_q <= 1'b0; cs_q <= 1'b1; wel <= 1'b0; outph <= 1'b0;
      bitcnt <= '0; bytecnt <= '0; prot <= '0; sh <= '0;
      op <= '0; wdata <= '0; out_sh <= '0; addr <= '0; busy_cnt <= '0;
      for (int i = 0; i < DEPTH; i++) mem[i] <= 8'hFF;
    end else begin
      sclk_q <= sclk;
      cs_q   <= cs_n;
      if (busy) busy_cnt <= busy_cnt - 1'b1;
      if (cs_n) begin
        bitcnt <= '0; bytecnt <= '0; op <= '0; outph <= 1'b0;
      end else if (rise) begin
        sh     <= byte_in[6:0];
        bitcnt <= bitcnt + 1'b1;
        if (byte_done) begin
          if (bytecnt != 3'd7) bytecnt <= bytecnt + 1'b1;
          if (bytecnt == 3'd0) begin
            op <= byte_in;
            if (byte_in == OP_RDSR) begin out_sh <= status; outph <= 1'b1; end
          end else if (outph) begin
            case (op)
              OP_RDSR: out_sh <= status;
              OP_READ: begin out_sh <= mem[addr]; addr <= addr + 1'b1; end
              default: out_sh <= SILICON_ID;
            endcase
          end else begin
            if (bytecnt <= 3'd3 && (op == OP_READ || op == OP_PROG || op == OP_SE))
              addr <= addr_nx;
            if (bytecnt == 3'd3 && op == OP_READ) begin
              out_sh <= mem[addr_nx]; addr <= addr_nx + 1'b1; outph <= 1'b1;
            end
            if (bytecnt == 3'd3 && op == OP_RDID) begin
              out_sh <= SILICON_ID; outph <= 1'b1;
            end
            if ((op == OP_PROG && bytecnt == 3'd4) || (op == OP_WRSR && bytecnt == 3'd1))
              wdata <= byte_in;
          end
        end else if (outph) out_sh <= {out_sh[6:0], 1'b0};
      end
      if (commit && op == OP_WREN) wel <= 1'b1;
      if (commit && op == OP_WRDI) wel <= 1'b0;
      if (do_mod) begin
        wel      <= 1'b0;
        busy_cnt <= BW'(BUSY_CLKS);
        case (op)
          OP_PROG: mem[addr] <= mem[addr] & wdata;
          OP_WRSR: prot <= wdata[4:2];
          default:
            for (int i = 0; i < DEPTH; i++)
              if (op == OP_BE || 2'(i / SECTOR_BYTES) == addr[AW-1 -: 2]) mem[i] <= 8'hFF;
        endcase
      end
    end
  end

  AST_OE_AFTER_OPCODE: assert property (@(posedge clk) disable iff (!rst_n)
    sdo_oe |-> bytecnt != 3'd0);  // R6
  AST_COUNT_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    cs_n |=> (bitcnt == 3'd0 && bytecnt == 3'd0));  // R1
  AST_WEL_FROM_WREN: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(wel) |-> $past(cs_n && !cs_q && bitcnt == 3'd0 && op == OP_WREN));  // R7
  AST_MISALIGNED_NO_EFFECT: assert property (@(posedge clk) disable iff (!rst_n)
    (cs_n && !cs_q && bitcnt != 3'd0) |=> ($stable(wel) && !$rose(busy)));  // R8
  AST_BUSY_NEEDS_WEL: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> ($past(wel) && $past(cs_n && !cs_q)));  // R12
endmodule

// File: tb/tb_flash_cmd_engine.sv
module tb_flash_cmd_engine;
  localparam int CLK_PERIOD = 10;
  localparam int SECB  = 32;
  localparam int DEPTH = 4 * SECB;
  localparam int BUSY  = 200;
  localparam logic [7:0] ID = 8'h10;

  logic clk = 1'b0, rst_n = 1'b0, cs_n = 1'b1, sclk = 1'b0, sdi = 1'b0;
  logic sdo, sdo_oe;
  int checks = 0, fails = 0;
  logic [7:0] model [DEPTH];
  logic [7:0] rd [256];
  logic [7:0] junk;

  always #(CLK_PERIOD / 2) clk = ~clk;

  flash_cmd_engine dut (.clk(clk), .rst_n(rst_n), .cs_n(cs_n), .sclk(sclk),
                        .sdi(sdi), .sdo(sdo), .sdo_oe(sdo_oe));

  task automatic check(input bit ok, input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic sbit(input logic b, output logic r);
    sdi = b;
    repeat (2) @(negedge clk);
    r = sdo;
    sclk = 1'b1;
    repeat (2) @(negedge clk);
    sclk = 1'b0;
  endtask

  task automatic sbyte(input logic [7:0] b, output logic [7:0] r);
    for (int i = 7; i >= 0; i--) sbit(b[i], r[i]);
  endtask

  task automatic sel();
    cs_n = 1'b0;
    repeat (2) @(negedge clk);
  endtask

  task automatic desel();
    cs_n = 1'b1;
    repeat (3) @(negedge clk);
  endtask

  task automatic cmd1(input logic [7:0] op);
    sel(); sbyte(op, junk); desel();
  endtask

  task automatic send_addr(input int a);
    sbyte(8'(a >> 16), junk); sbyte(8'(a >> 8), junk); sbyte(8'(a), junk);
  endtask

  task automatic rdsr(output logic [7:0] s);
    sel(); sbyte(8'h05, junk); sbyte(8'h00, s); desel();
  endtask

  task automatic read_mem(input int a, input int n);
    sel(); sbyte(8'h03, junk); send_addr(a);
    for (int k = 0; k < n; k++) sbyte(8'h00, rd[k]);
    desel();
  endtask

  task automatic prog(input int a, input logic [7:0] d);
    cmd1(8'h06);
    sel(); sbyte(8'h02, junk); send_addr(a); sbyte(d, junk); desel();
    repeat (BUSY + 8) @(negedge clk);
  endtask

  task automatic erase_sec(input int a);
    cmd1(8'h06);
    sel(); sbyte(8'hD8, junk); send_addr(a); desel();
    repeat (BUSY + 8) @(negedge clk);
  endtask

  task automatic verify_all(input string req);
    read_mem(0, DEPTH);
    for (int k = 0; k < DEPTH; k++) check(rd[k] == model[k], req, rd[k], model[k]);
  endtask

  initial begin
    repeat (CLK_PERIOD * 18000) @(posedge clk);
    fails++;
    $display("FAIL watchdog actual=%h expected=%h", 8'h00, 8'h01);
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    logic [7:0] s;
    logic b;
    for (int k = 0; k < DEPTH; k++) model[k] = 8'hFF;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);

    check(sdo_oe == 1'b0, "R6 reset oe", {7'd0, sdo_oe}, 8'h00);
    rdsr(s); check(s == 8'h00, "R4 reset status", s, 8'h00);

    // R5: identifier after three dummy bytes, repeated
    sel(); sbyte(8'hAB, junk);
    check(sdo_oe == 1'b0, "R6 no oe during dummies", {7'd0, sdo_oe}, 8'h00);
    repeat (3) sbyte(8'h00, junk);
    check(sdo_oe == 1'b1, "R6 oe in data phase", {7'd0, sdo_oe}, 8'h01);
    sbyte(8'h00, s); check(s == ID, "R5 id first", s, ID);
    sbyte(8'h00, s); check(s == ID, "R5 id repeat", s, ID);
    desel();
    check(sdo_oe == 1'b0, "R6 oe after deselect", {7'd0, sdo_oe}, 8'h00);

    // R2: unknown code
    sel(); sbyte(8'h9F, junk); sbyte(8'h00, junk);
    check(sdo_oe == 1'b0, "R2 unknown code silent", {7'd0, sdo_oe}, 8'h00);
    desel();
    rdsr(s); check(s == 8'h00, "R2 unknown code no state", s, 8'h00);

    // R7 / R8: latch set, clear, misaligned set
    cmd1(8'h06); rdsr(s); check(s == 8'h02, "R7 set latch", s, 8'h02);
    cmd1(8'h04); rdsr(s); check(s == 8'h00, "R7 clear latch", s, 8'h00);
    sel(); sbyte(8'h06, junk); sbit(1'b0, b); sbit(1'b0, b); sbit(1'b1, b); desel();
    rdsr(s); check(s == 8'h00, "R8 misaligned set ignored", s, 8'h00);

    // R9: program without latch
    sel(); sbyte(8'h02, junk); send_addr(3); sbyte(8'h00, junk); desel();
    read_mem(3, 1); check(rd[0] == 8'hFF, "R9 no latch no program", rd[0], 8'hFF);

    // R9: program every byte, then AND a second pattern into some
    for (int a = 0; a < DEPTH; a++) begin
      logic [7:0] d = 8'(a * 29 + 7) ^ 8'h3C;
      prog(a, d); model[a] = model[a] & d;
    end
    for (int a = 0; a < DEPTH; a += 5) begin
      logic [7:0] d = ~8'(a) ^ 8'h81;
      prog(a, d); model[a] = model[a] & d;
    end
    rdsr(s); check(s == 8'h00, "R12 latch cleared by program", s, 8'h00);

    // R3: sequential read with wrap
    read_mem(0, DEPTH + 2);
    for (int k = 0; k < DEPTH + 2; k++)
      check(rd[k] == model[k % DEPTH], "R3 R9 sequential read", rd[k], model[k % DEPTH]);
    read_mem(DEPTH - 2, 4);
    for (int k = 0; k < 4; k++)
      check(rd[k] == model[(DEPTH - 2 + k) % DEPTH], "R3 wrap", rd[k], model[(DEPTH - 2 + k) % DEPTH]);

    // R8: misaligned program rejected, latch kept
    cmd1(8'h06);
    sel(); sbyte(8'h02, junk); send_addr(10); sbyte(8'h00, junk); sbit(1'b0, b); desel();
    repeat (8) @(negedge clk);
    read_mem(10, 1); check(rd[0] == model[10], "R8 misaligned program", rd[0], model[10]);
    rdsr(s); check(s == 8'h02, "R8 latch kept on reject", s, 8'h02);
    cmd1(8'h04);

    // R10: sector erase by top address bits
    erase_sec(SECB + 7);
    for (int k = SECB; k < 2 * SECB; k++) model[k] = 8'hFF;
    verify_all("R10 sector 1 erase");
    erase_sec(2 * SECB + SECB - 1);
    for (int k = 2 * SECB; k < 3 * SECB; k++) model[k] = 8'hFF;
    verify_all("R10 sector 2 erase");

    // R11 / R12: status write, busy, rejection while busy
    cmd1(8'h06);
    sel(); sbyte(8'h01, junk); sbyte(8'h1C, junk); desel();
    rdsr(s); check(s == 8'h1D, "R11 R12 status busy", s, 8'h1D);
    cmd1(8'h06);
    cmd1(8'hC7);
    repeat (BUSY + 8) @(negedge clk);
    rdsr(s); check(s == 8'h1E, "R12 busy reject keeps latch", s, 8'h1E);
    verify_all("R12 erase rejected while busy");

    // R10: full erase
    cmd1(8'hC7);
    repeat (BUSY + 8) @(negedge clk);
    for (int k = 0; k < DEPTH; k++) model[k] = 8'hFF;
    verify_all("R10 full erase");
    rdsr(s); check(s == 8'h1C, "R11 R12 status after erase", s, 8'h1C);

    // R4 / R1: partial status read, then a normal transaction
    sel(); sbyte(8'h05, junk); sbit(1'b0, b); sbit(1'b0, b); sbit(1'b0, b); desel();
    rdsr(s); check(s == 8'h1C, "R4 R1 after partial read", s, 8'h1C);
    sel(); sbyte(8'hAB, junk); repeat (3) sbyte(8'h00, junk); sbyte(8'h00, s); desel();
    check(s == ID, "R1 counters reset", s, ID);

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule